// File: doc/BRIEF.md
# HDLC Channel FIFO DMA Handshake Controller

This block couples one HDLC channel's receive and transmit byte FIFOs, both held inside it, to an external DMA engine. On the receive side it raises a request whenever a whole block of bytes, or the shorter tail of a finished frame, is waiting. It keeps that request up until exactly that many bytes have been read out. On the transmit side software first loads a byte count. The block then requests bursts, each no longer than the selected block size, for as long as bytes remain and the FIFO has room for a full block.

A small byte-wide register bus gives addressed access to the configuration, the byte count, both fill levels and a FIFO data port. When the active-low DMA acknowledge is driven low, the address is disregarded. A read strobe then pops the head of the receive FIFO and a write strobe pushes into the transmit FIFO. With the acknowledge tied high, the FIFOs are reached only through the data port address.

The line side pushes received bytes, each with an end-of-frame flag, and pops bytes queued for transmission.

Top module: `hdlc_dma_ctl`

## Requirements
- R1: After reset both requests are low, both fill levels read 0, the block code reads 0 and the byte count reads 0.
- R2: Block code field CFG[1:0] at address 1 selects the block size 32, 16, 8 or 4 bytes for codes 0, 1, 2 and 3. The receive request rises one clock after the receive fill level reaches the block size, and not before.
- R3: Once raised, the receive request stays high until exactly one block has been popped. It is low in the cycle after the last pop, and rises again one cycle later if another block is already waiting.
- R4: A byte pushed with the end-of-frame flag makes the bytes up to and including it a tail. Such a tail raises the receive request even below the block size, and the request covers exactly the tail length.
- R5: The 12-bit transmit byte count is written as its low 8 bits at address 2 and its upper 4 bits in data bits [3:0] at address 3, and both addresses read it back.
- R6: The transmit request rises one clock after the count is non-zero while the transmit FIFO has at least one block of free space. Each burst lasts for the smaller of the block size and the remaining count in acknowledged writes.
- R7: Every acknowledged write that enters the transmit FIFO decrements the count by one. At zero no further transmit request is raised.
- R8: No transmit request is raised while the transmit FIFO has less free space than one block. It is raised once the line side frees enough room.
- R9: While the acknowledge is low, the address is ignored: a read returns and pops the receive head, and a write pushes into the transmit FIFO without changing any register.
- R10: With the acknowledge high, only address 0 reaches the FIFOs. Addressed writes there push without changing the byte count, and reads of other addresses pop nothing.
- R11: An access with neither strobe, or with both strobes together, changes neither FIFO nor the byte count.
- R12: A pop from an empty receive FIFO returns 0 and changes nothing, and a push into a full transmit FIFO (64 bytes) is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address: 0 data, 1 config, 2 count low, 3 count high, 4 receive level, 5 transmit level |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| bus_rd | input | 1 | Read strobe, one pop per clock while high |
| bus_wr | input | 1 | Write strobe, one push or register write per clock while high |
| dack_n | input | 1 | DMA acknowledge, active low; low selects the FIFOs implicitly |
| rx_drq | output | 1 | Receive DMA request |
| tx_drq | output | 1 | Transmit DMA request |
| rx_in_valid | input | 1 | Line side pushes a received byte |
| rx_in_data | input | 8 | Received byte |
| rx_in_eof | input | 1 | Pushed byte ends a frame |
| tx_out_pop | input | 1 | Line side takes one transmit byte |
| tx_out_data | output | 8 | Head of the transmit FIFO |
| tx_out_valid | output | 1 | Transmit FIFO not empty |

## Verification
The bench looks for requests that are off by one block or one cycle. A design that compared the fill level with "greater than" would raise the receive request one byte late, and one that failed to latch the burst length would drop the request early or keep it up past the block. Frame tails shorter than a block are pushed to catch a design that waits forever for a full block. Accesses with the acknowledge low and the address pointing at a register would catch a design that still decodes the address and corrupts the configuration. Clashing strobes, full and empty FIFOs, and a count smaller than the block size are also driven, so that a design that pushed twice, underflowed the count or overran the FIFO shows wrong levels or wrong data.

// File: rtl/hdlc_dma_pkg.sv
package hdlc_dma_pkg;
  typedef enum logic [2:0] {
    REG_DATA   = 3'd0,
    REG_CFG    = 3'd1,
    REG_CNT_LO = 3'd2,
    REG_CNT_HI = 3'd3,
    REG_RX_LVL = 3'd4,
    REG_TX_LVL = 3'd5
  } reg_addr_e;

  // Block size for a 2-bit code: 32 >> code.
  function automatic logic [6:0] blk_bytes(input logic [1:0] code);
    return 7'd32 >> code;
  endfunction
endpackage

// File: rtl/hdlc_byte_fifo.sv
module hdlc_byte_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,   // caller guarantees !full
  input  logic [DW-1:0] wdata,
  input  logic          pop,    // caller guarantees !empty
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      if (push && !pop)      level <= level + LW'(1);
      else if (pop && !push) level <= level - LW'(1);
    end
  end

  assign rdata = mem[rd_ptr];
  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
endmodule

// File: rtl/hdlc_dma_burst.sv
module hdlc_dma_burst #(
  parameter int unsigned LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ok,
  input  logic [LW-1:0] len,
  input  logic          step,
  output logic          req
);
  logic          busy;
  logic [LW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
    end else if (!busy) begin
      if (start_ok && len != '0) begin
        busy <= 1'b1;
        left <= len;
      end
    end else if (step) begin
      left <= left - LW'(1);
      if (left == LW'(1)) busy <= 1'b0;
    end
  end

  assign req = busy;
endmodule

// File: rtl/hdlc_dma_ctl.sv
module hdlc_dma_ctl
  import hdlc_dma_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = 12,
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic       dack_n,
  output logic       rx_drq,
  output logic       tx_drq,
  input  logic       rx_in_valid,
  input  logic [7:0] rx_in_data,
  input  logic       rx_in_eof,
  input  logic       tx_out_pop,
  output logic [7:0] tx_out_data,
  output logic       tx_out_valid
);
  // Named internal events
  logic             dack, fifo_sel, rd_only, wr_only;
  logic             rx_pop, tx_push, reg_wr, rx_line_push, tx_line_pop;
  logic [LW-1:0]    rx_level, tx_level, rx_fb, blk, rx_len, tx_len, tx_free;
  logic             rx_full, rx_empty, tx_full, tx_empty, rx_ready, tx_ready;
  logic [7:0]       rx_head;
  logic [1:0]       blk_code;
  logic [CNT_W-1:0] tx_cnt;

  assign dack     = !dack_n;
  assign rd_only  = bus_rd && !bus_wr;
  assign wr_only  = bus_wr && !bus_rd;
  assign fifo_sel = dack || (bus_addr == REG_DATA);
  assign rx_pop   = rd_only && fifo_sel && !rx_empty;
  assign tx_push  = wr_only && fifo_sel && !tx_full;
  assign reg_wr   = wr_only && !dack;
  assign rx_line_push = rx_in_valid && !rx_full;
  assign tx_line_pop  = tx_out_pop && !tx_empty;

  hdlc_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_line_push), .wdata(rx_in_data),
    .pop(rx_pop), .rdata(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  hdlc_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata),
    .pop(tx_line_pop), .rdata(tx_out_data), .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  // Configuration, byte count and frame-tail tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_code <= 2'd0;
      tx_cnt   <= '0;
      rx_fb    <= '0;
    end else begin
      if (reg_wr && bus_addr == REG_CFG) blk_code <= bus_wdata[1:0];

      if (reg_wr && bus_addr == REG_CNT_LO)
        tx_cnt[7:0] <= bus_wdata;
      else if (reg_wr && bus_addr == REG_CNT_HI)
        tx_cnt[CNT_W-1:8] <= bus_wdata[CNT_W-9:0];
      else if (tx_push && dack && tx_cnt != '0)
        tx_cnt <= tx_cnt - CNT_W'(1);

      if (rx_line_push && rx_in_eof)
        rx_fb <= rx_level + LW'(1) - (rx_pop ? LW'(1) : LW'(0));
      else if (rx_pop && rx_fb != '0)
        rx_fb <= rx_fb - LW'(1);
    end
  end

  assign blk      = LW'(blk_bytes(blk_code));
  assign rx_ready = (rx_level >= blk);
  assign rx_len   = rx_ready ? blk : rx_fb;
  assign tx_free  = LW'(DEPTH) - tx_level;
  assign tx_ready = (tx_cnt != '0) && (tx_free >= blk);
  assign tx_len   = (tx_cnt < CNT_W'(blk)) ? LW'(tx_cnt) : blk;
  assign tx_out_valid = !tx_empty;

  hdlc_dma_burst #(.LW(LW)) u_rx_burst (
    .clk(clk), .rst_n(rst_n), .start_ok(rx_ready || rx_fb != '0),
    .len(rx_len), .step(rx_pop), .req(rx_drq)
  );

  hdlc_dma_burst #(.LW(LW)) u_tx_burst (
    .clk(clk), .rst_n(rst_n), .start_ok(tx_ready),
    .len(tx_len), .step(tx_push && dack), .req(tx_drq)
  );

  // Read data
  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd && fifo_sel) begin
      bus_rdata = rx_empty ? 8'h00 : rx_head;
    end else begin
      case (bus_addr)
        REG_CFG:    bus_rdata = {6'd0, blk_code};
        REG_CNT_LO: bus_rdata = tx_cnt[7:0];
        REG_CNT_HI: bus_rdata = 8'(tx_cnt >> 8);
        REG_RX_LVL: bus_rdata = 8'(rx_level);
        REG_TX_LVL: bus_rdata = 8'(tx_level);
        default:    bus_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/hdlc_dma_chk.sv
module hdlc_dma_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LW    = 7,
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dack_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [LW-1:0]    rx_level,
  input logic             rx_pop,
  input logic             tx_push,
  input logic [CNT_W-1:0] tx_cnt,
  input logic             rx_drq,
  input logic             tx_drq
);
  // R11
  strobe_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr) |-> (!rx_pop && !tx_push));

  // R12
  rx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH));

  // R7
  cnt_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && !dack_n && tx_cnt != '0) |=> (tx_cnt == $past(tx_cnt) - CNT_W'(1)));

  // R10
  addr_push_keeps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && dack_n) |=> (tx_cnt == $past(tx_cnt)));

  // R3
  rx_drop_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_drq) |-> $past(rx_pop));

  // R6
  tx_rise_needs_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_drq) |-> ($past(tx_cnt) != '0));

  // R9
  dack_read_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dack_n && bus_rd && !bus_wr && rx_level != '0) |-> rx_pop);
endmodule

bind hdlc_dma_ctl hdlc_dma_chk #(.DEPTH(DEPTH), .LW(LW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dack_n(dack_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .rx_level(rx_level), .rx_pop(rx_pop), .tx_push(tx_push), .tx_cnt(tx_cnt),
  .rx_drq(rx_drq), .tx_drq(tx_drq)
);

// File: tb/tb_hdlc_dma_ctl.sv
module tb_hdlc_dma_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       bus_rd = 1'b0, bus_wr = 1'b0, dack_n = 1'b1;
  logic       rx_drq, tx_drq;
  logic       rx_in_valid = 1'b0, rx_in_eof = 1'b0, tx_out_pop = 1'b0;
  logic [7:0] rx_in_data = 8'd0;
  logic [7:0] tx_out_data;
  logic       tx_out_valid;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hdlc_dma_ctl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr), .dack_n(dack_n),
    .rx_drq(rx_drq), .tx_drq(tx_drq), .rx_in_valid(rx_in_valid),
    .rx_in_data(rx_in_data), .rx_in_eof(rx_in_eof), .tx_out_pop(tx_out_pop),
    .tx_out_data(tx_out_data), .tx_out_valid(tx_out_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic dn);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; dack_n = dn;
    @(negedge clk);
    bus_wr = 1'b0; dack_n = 1'b1;
  endtask

  task automatic rd(input logic [2:0] a, input logic dn, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; dack_n = dn;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; dack_n = 1'b1;
  endtask

  task automatic rx_put(input logic [7:0] d, input logic eof);
    @(negedge clk);
    rx_in_valid = 1'b1; rx_in_data = d; rx_in_eof = eof;
    @(negedge clk);
    rx_in_valid = 1'b0; rx_in_eof = 1'b0;
  endtask

  task automatic tx_take(output logic [7:0] d);
    @(negedge clk);
    tx_out_pop = 1'b1;
    #1 d = tx_out_data;
    @(negedge clk);
    tx_out_pop = 1'b0;
  endtask

  function automatic int blk_of(input int code);
    return 32 / (1 << code);
  endfunction

  task automatic test_reset();
    logic [7:0] d;
    check("R1 rx_drq", rx_drq, 0);
    check("R1 tx_drq", tx_drq, 0);
    rd(3'd1, 1'b1, d); check("R1 cfg", d, 0);
    rd(3'd2, 1'b1, d); check("R1 cnt lo", d, 0);
    rd(3'd3, 1'b1, d); check("R1 cnt hi", d, 0);
    rd(3'd4, 1'b1, d); check("R1 rx level", d, 0);
    rd(3'd5, 1'b1, d); check("R1 tx level", d, 0);
  endtask

  task automatic test_rx_block(input int code);
    logic [7:0] d;
    int blk = blk_of(code);
    wr(3'd1, 8'(code), 1'b1);
    for (int i = 0; i < blk - 1; i++) rx_put(8'(code * 50 + i), 1'b0);
    @(negedge clk); @(negedge clk);
    check("R2 no request below block", rx_drq, 0);
    rx_put(8'(code * 50 + blk - 1), 1'b0);
    check("R2 request not yet", rx_drq, 0);
    @(negedge clk);
    check("R2 request one clock after block", rx_drq, 1);
    for (int i = 0; i < blk; i++) begin
      if (i == blk - 1) check("R3 request held to last byte", rx_drq, 1);
      rd(3'd1, 1'b0, d);
      check("R9 dma read data", d, (code * 50 + i) & 255);
    end
    check("R3 request low after block", rx_drq, 0);
    rd(3'd1, 1'b1, d); check("R9 cfg unchanged by dma read", d, code);
  endtask

  task automatic test_rx_b2b();
    logic [7:0] d;
    wr(3'd1, 8'd3, 1'b1);
    for (int i = 0; i < 8; i++) rx_put(8'(200 + i), 1'b0);
    @(negedge clk);
    check("R3 first block request", rx_drq, 1);
    for (int i = 0; i < 4; i++) rd(3'd0, 1'b0, d);
    check("R3 gap after block", rx_drq, 0);
    @(negedge clk);
    check("R3 second block reasserts", rx_drq, 1);
    for (int i = 0; i < 4; i++) begin
      rd(3'd0, 1'b0, d);
      check("R3 second block data", d, 204 + i);
    end
    check("R3 low after second block", rx_drq, 0);
  endtask

  task automatic test_eof_tail();
    logic [7:0] d;
    wr(3'd1, 8'd2, 1'b1);
    rx_put(8'd31, 1'b0);
    rx_put(8'd32, 1'b0);
    @(negedge clk); @(negedge clk);
    check("R4 no request before frame end", rx_drq, 0);
    rx_put(8'd33, 1'b1);
    @(negedge clk);
    check("R4 tail raises request", rx_drq, 1);
    for (int i = 0; i < 3; i++) begin
      if (i == 2) check("R4 held for tail", rx_drq, 1);
      rd(3'd0, 1'b0, d);
      check("R4 tail data", d, 31 + i);
    end
    check("R4 drops after tail", rx_drq, 0);
    @(negedge clk); @(negedge clk);
    check("R4 stays low when empty", rx_drq, 0);
  endtask

  task automatic test_full_empty_count();
    logic [7:0] d;
    rd(3'd0, 1'b0, d);
    check("R12 empty pop returns 0", d, 0);
    rd(3'd4, 1'b1, d); check("R12 empty pop keeps level", d, 0);
    for (int i = 0; i < 64; i++) wr(3'd0, 8'(i), 1'b1);
    rd(3'd5, 1'b1, d); check("R12 tx full level", d, 64);
    wr(3'd0, 8'hEE, 1'b1);
    rd(3'd5, 1'b1, d); check("R12 push to full dropped", d, 64);
    wr(3'd2, 8'h05, 1'b1);
    wr(3'd3, 8'hA3, 1'b1);
    rd(3'd2, 1'b1, d); check("R5 count low", d, 8'h05);
    rd(3'd3, 1'b1, d); check("R5 count high nibble", d, 8'h03);
    @(negedge clk); @(negedge clk);
    check("R8 no request when full", tx_drq, 0);
    wr(3'd2, 8'h00, 1'b1);
    wr(3'd3, 8'h00, 1'b1);
    rd(3'd2, 1'b1, d); check("R5 count cleared", d, 0);
    for (int i = 0; i < 64; i++) begin
      tx_take(d);
      check("R12 tx data order", d, i);
    end
    check("R12 tx empty", tx_out_valid, 0);
  endtask

  task automatic test_tx_bursts();
    logic [7:0] d;
    wr(3'd1, 8'd3, 1'b1);
    wr(3'd2, 8'd6, 1'b1);
    check("R6 request not yet", tx_drq, 0);
    @(negedge clk);
    check("R6 request rises", tx_drq, 1);
    for (int i = 0; i < 4; i++) wr(3'd1, 8'(100 + i), 1'b0);
    check("R6 burst ends after block", tx_drq, 0);
    rd(3'd2, 1'b1, d); check("R7 count after burst", d, 2);
    check("R6 short burst requested", tx_drq, 1);
    wr(3'd2, 8'd104, 1'b0);
    wr(3'd3, 8'd105, 1'b0);
    check("R6 short burst length", tx_drq, 0);
    rd(3'd2, 1'b1, d); check("R7 count at zero", d, 0);
    @(negedge clk); @(negedge clk);
    check("R7 no request at zero", tx_drq, 0);
    rd(3'd1, 1'b1, d); check("R9 cfg not written by dma", d, 3);
    rd(3'd5, 1'b1, d); check("R9 dma writes pushed", d, 6);
    for (int i = 0; i < 6; i++) begin
      tx_take(d);
      check("R9 dma write data", d, 100 + i);
    end
  endtask

  task automatic test_tx_room();
    logic [7:0] d;
    wr(3'd1, 8'd0, 1'b1);
    for (int i = 0; i < 40; i++) wr(3'd0, 8'(i), 1'b1);
    wr(3'd2, 8'd10, 1'b1);
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R8 no request without room", tx_drq, 0);
    for (int i = 0; i < 8; i++) tx_take(d);
    @(negedge clk);
    check("R8 request once room frees", tx_drq, 1);
    for (int i = 0; i < 10; i++) wr(3'd4, 8'(150 + i), 1'b0);
    check("R6 burst limited by count", tx_drq, 0);
    rd(3'd2, 1'b1, d); check("R7 count drained", d, 0);
    for (int i = 0; i < 42; i++) begin
      tx_take(d);
      check("R8 tx data", d, (i < 32) ? i + 8 : 150 + i - 32);
    end
  endtask

  task automatic test_strobes();
    logic [7:0] d;
    wr(3'd1, 8'd3, 1'b1);
    rx_put(8'd71, 1'b0);
    rx_put(8'd72, 1'b0);
    wr(3'd2, 8'd3, 1'b1);
    wr(3'd0, 8'd90, 1'b1);
    rd(3'd2, 1'b1, d); check("R10 addressed push keeps count", d, 3);
    @(negedge clk); dack_n = 1'b0;
    @(negedge clk); @(negedge clk); dack_n = 1'b1;
    rd(3'd4, 1'b1, d); check("R11 idle ack keeps rx", d, 2);
    rd(3'd5, 1'b1, d); check("R11 idle ack keeps tx", d, 1);
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; dack_n = 1'b0; bus_wdata = 8'd1;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; dack_n = 1'b1;
    rd(3'd4, 1'b1, d); check("R11 clash keeps rx", d, 2);
    rd(3'd5, 1'b1, d); check("R11 clash keeps tx", d, 1);
    rd(3'd2, 1'b1, d); check("R11 clash keeps count", d, 3);
    rd(3'd4, 1'b1, d); check("R10 register read pops nothing", d, 2);
    rd(3'd0, 1'b1, d); check("R10 addressed pop data", d, 71);
    rd(3'd4, 1'b1, d); check("R10 addressed pop level", d, 1);
    for (int i = 0; i < 3; i++) wr(3'd0, 8'(91 + i), 1'b0);
    check("R7 done after count", tx_drq, 0);
    for (int i = 0; i < 4; i++) begin
      tx_take(d);
      check("R10 tx data", d, 90 + i);
    end
    rd(3'd0, 1'b0, d); check("R9 remaining rx byte", d, 72);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_rx_block(3);
    test_rx_block(2);
    test_rx_block(1);
    test_rx_block(0);
    test_rx_b2b();
    test_eof_tail();
    test_full_empty_count();
    test_tx_bursts();
    test_tx_room();
    test_strobes();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule